// File: doc/BRIEF.md
# E1 Timeslot Zero Transmitter

This block produces the serial bit stream for timeslot 0 of a 2.048 Mbit/s PCM frame made of 32 eight-bit timeslots. It runs on the 2.048 MHz bit clock. A one-cycle frame-start strobe places the frame in time. One frame carries the frame-alignment word in timeslot 0 and the next frame carries the non-alignment word. A status output reports which of the two words the current frame holds.

The first bit of either word is not generated here. It is taken from a serial input, which the CRC generator next to this block normally drives. Six parallel user bits fill the tail of the non-alignment word. Outside timeslot 0 the data output is held low, so a downstream multiplexer can merge the output with the other timeslots. After one strobe the block keeps counting frames by itself. A later strobe realigns the frame at once, even in the middle of a frame.

Top module: `ts0_tx`

## Requirements
- R1: After reset, and until the first frame-start strobe is sampled, `tx_data` and `align_frame` are both 0, whatever the other inputs do.
- R2: The clock edge that samples `frame_start` high starts a frame. The 8 bits of the word appear on `tx_data` in the 8 cycles that follow that edge, bit 1 first and bit 8 last.
- R3: In an alignment frame, bit 1 is the value of `intl_bit` at the starting edge and bits 2 to 8 are 0,0,1,1,0,1,1.
- R4: In a non-alignment frame, bit 1 is the value of `intl_bit` at the starting edge and bit 2 is 1. Bits 3 to 8 are `user_bits[5]` down to `user_bits[0]`, so `user_bits[5]` is bit 3.
- R5: Frames strictly alternate between the two word types. The first frame after reset is an alignment frame.
- R6: `align_frame` is 1 throughout an alignment frame and 0 throughout a non-alignment frame. It changes only on an edge that starts a frame.
- R7: In every cycle of a frame after its first 8 bit periods, `tx_data` is 0.
- R8: `user_bits` and `intl_bit` are sampled only at the edge that starts a frame. Changes to them during timeslot 0 do not affect the word being sent.
- R9: Once a frame has started, and with no further strobe, a new frame begins every SLOTS×8 cycles, and the word type keeps alternating.
- R10: A strobe that arrives before the current frame ends, including one inside timeslot 0, starts a new frame at that edge and switches the word type.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, 2.048 MHz in the target system |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_start | input | 1 | One-cycle strobe marking the first bit of a frame |
| intl_bit | input | 1 | Serial source for bit 1 of both word types |
| user_bits | input | 6 | User bits 3 to 8 of the non-alignment word, MSB first |
| tx_data | output | 1 | Serial timeslot 0 data, low outside timeslot 0 |
| align_frame | output | 1 | High while the current frame carries the alignment word |

## Verification
The bench builds the block with SLOTS = 4, which gives a 32-cycle frame. With a frame that short, 128 back-to-back frames fit in a few thousand cycles. In that run every one of the 64 user-bit patterns is sent in a non-alignment frame, and both values of the serial first bit appear with both word types. The sweep mixes frames started by a strobe with frames started by the free-running counter. Some frames also change the inputs during the slot. Early strobes, both inside timeslot 0 and later in the frame, test the realignment path.

// File: rtl/ts0_pkg.sv
// Package: shared constants and word assembly for the timeslot 0 transmitter.
// Assumes an 8-bit timeslot and the fixed E1 word layout, bit 1 sent first.
package ts0_pkg;

    localparam int SLOT_BITS = 8;
    localparam int USER_W    = 6;

    // Bits 2..8 of the alignment word, bit 2 in the MSB position.
    localparam logic [SLOT_BITS-2:0] ALIGN_TAIL = 7'b0011011;

    // Assemble one word, bit 1 in the MSB, ready for MSB-first shifting.
    function automatic logic [SLOT_BITS-1:0] build_word(
        input logic              is_align,
        input logic              first_bit,
        input logic [USER_W-1:0] user
    );
        if (is_align)
            return {first_bit, ALIGN_TAIL};
        else
            return {first_bit, 1'b1, user};
    endfunction

endpackage

// File: rtl/ts0_frame_timer.sv
// Module: frame position counter.
// Tracks the bit position within the frame. It flags the edge that starts a
// frame (a strobe, or wrap-around once synced) and the bit periods of
// timeslot 0. Assumes SLOTS >= 2.
module ts0_frame_timer #(
    parameter int SLOTS = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic frame_start,
    output logic frame_begin,
    output logic in_slot
);
    import ts0_pkg::*;

    localparam int FRAME_LEN = SLOTS * SLOT_BITS;
    localparam int POS_W     = $clog2(FRAME_LEN);
    localparam logic [POS_W-1:0] LAST_POS = POS_W'(FRAME_LEN - 1);
    localparam logic [POS_W-1:0] SLOT_END = POS_W'(SLOT_BITS);

    logic [POS_W-1:0] pos_q;
    logic [POS_W-1:0] pos_d;
    logic             synced_q;

    // Frame starts on a strobe, or on wrap-around once a strobe has been seen.
    assign frame_begin = frame_start | (synced_q & (pos_q == LAST_POS));

    // Next bit position: restart at zero on a frame start.
    assign pos_d = frame_begin ? '0 : pos_q + 1'b1;

    // Position, sync flag and timeslot-0 window registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_q    <= '0;
            synced_q <= 1'b0;
            in_slot  <= 1'b0;
        end else begin
            pos_q    <= pos_d;
            synced_q <= synced_q | frame_start;
            in_slot  <= (synced_q | frame_start) && (pos_d < SLOT_END);
        end
    end

endmodule

// File: rtl/ts0_word_sel.sv
// Module: word-type alternation and word assembly.
// Flips the frame type at every frame start. It presents the word for the
// frame about to begin, built from the inputs as they are at that edge.
module ts0_word_sel (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         frame_begin,
    input  logic                         intl_bit,
    input  logic [ts0_pkg::USER_W-1:0]   user_bits,
    output logic                         align_q,
    output logic [ts0_pkg::SLOT_BITS-1:0] next_word
);
    import ts0_pkg::*;

    // Word for the next frame: its type is the inverse of the current one.
    assign next_word = build_word(~align_q, intl_bit, user_bits);

    // Frame-type flag, held for the whole frame.
    always_ff @(posedge clk) begin
        if (!rst_n)
            align_q <= 1'b0;
        else if (frame_begin)
            align_q <= ~align_q;
    end

endmodule

// File: rtl/ts0_shifter.sv
// Module: MSB-first serializer.
// Loads the word at a frame start and shifts it out one bit per cycle. The
// output is gated low outside timeslot 0.
module ts0_shifter (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          load,
    input  logic                          in_slot,
    input  logic [ts0_pkg::SLOT_BITS-1:0] word,
    output logic                          ser_out
);
    import ts0_pkg::*;

    logic [SLOT_BITS-1:0] sreg_q;

    // Shift register: load on frame start, otherwise shift toward the MSB.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sreg_q <= '0;
        else if (load)
            sreg_q <= word;
        else
            sreg_q <= {sreg_q[SLOT_BITS-2:0], 1'b0};
    end

    // Serial output, only during timeslot 0.
    assign ser_out = in_slot & sreg_q[SLOT_BITS-1];

endmodule

// File: rtl/ts0_tx.sv
// Module: E1 timeslot 0 transmitter, top level.
// Sends the alignment and non-alignment words in alternate frames, with bit 1
// taken from a serial input. Assumes a one-cycle frame_start strobe on the
// bit clock.
module ts0_tx #(
    parameter int SLOTS = 32
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       frame_start,
    input  logic       intl_bit,
    input  logic [5:0] user_bits,
    output logic       tx_data,
    output logic       align_frame
);
    import ts0_pkg::*;

    logic                 frame_begin;
    logic                 in_slot;
    logic [SLOT_BITS-1:0] next_word;

    // Bit position and timeslot 0 window.
    ts0_frame_timer #(.SLOTS(SLOTS)) u_timer (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_start (frame_start),
        .frame_begin (frame_begin),
        .in_slot     (in_slot)
    );

    // Frame type and word contents.
    ts0_word_sel u_word (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_begin (frame_begin),
        .intl_bit    (intl_bit),
        .user_bits   (user_bits),
        .align_q     (align_frame),
        .next_word   (next_word)
    );

    // Serial output.
    ts0_shifter u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (frame_begin),
        .in_slot (in_slot),
        .word    (next_word),
        .ser_out (tx_data)
    );

endmodule

// File: rtl/ts0_tx_chk.sv
// Module: property checker for ts0_tx, attached by bind.
// Keeps its own frame position from the ports only.
module ts0_tx_chk #(
    parameter int SLOTS = 32
) (
    input logic       clk,
    input logic       rst_n,
    input logic       frame_start,
    input logic       intl_bit,
    input logic [5:0] user_bits,
    input logic       tx_data,
    input logic       align_frame
);
    localparam int FRAME_LEN = SLOTS * 8;
    localparam int POS_W     = $clog2(FRAME_LEN);
    localparam logic [POS_W-1:0] LAST_POS = POS_W'(FRAME_LEN - 1);
    localparam logic [POS_W-1:0] SLOT_END = POS_W'(8);

    logic             seen_q;
    logic [POS_W-1:0] cnt_q;

    // Observer state: whether a strobe was seen, and cycles since frame start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_q <= 1'b0;
            cnt_q  <= '0;
        end else begin
            seen_q <= seen_q | frame_start;
            if (frame_start || (seen_q && cnt_q == LAST_POS))
                cnt_q <= '0;
            else
                cnt_q <= cnt_q + 1'b1;
        end
    end

    AST_IDLE_BEFORE_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
        !seen_q |-> (!tx_data && !align_frame)); // R1

    AST_FIRST_BIT_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> (tx_data == $past(intl_bit))); // R2

    AST_STRICT_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> (align_frame != $past(align_frame))); // R5

    AST_STATUS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!frame_start && !(seen_q && cnt_q == LAST_POS)) |=> $stable(align_frame)); // R6

    AST_QUIET_OUTSIDE: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && cnt_q >= SLOT_END) |-> !tx_data); // R7

    AST_ALIGN_BIT2: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && cnt_q == POS_W'(1) && align_frame) |-> !tx_data); // R3

    AST_NONALIGN_BIT2: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && cnt_q == POS_W'(1) && !align_frame) |-> tx_data); // R4

endmodule

bind ts0_tx ts0_tx_chk #(.SLOTS(SLOTS)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_start (frame_start),
    .intl_bit    (intl_bit),
    .user_bits   (user_bits),
    .tx_data     (tx_data),
    .align_frame (align_frame)
);

// File: tb/ts0_tx_tb.sv
module ts0_tx_tb;
    localparam int SLOTS = 4;
    localparam int FRAME = SLOTS * 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       frame_start = 1'b0;
    logic       intl_bit = 1'b0;
    logic [5:0] user_bits = '0;
    logic       tx_data;
    logic       align_frame;

    int  checks = 0;
    int  failures = 0;
    bit  done = 1'b0;
    logic exp_align = 1'b0;

    always #5 clk = ~clk;

    ts0_tx #(.SLOTS(SLOTS)) u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_start (frame_start),
        .intl_bit    (intl_bit),
        .user_bits   (user_bits),
        .tx_data     (tx_data),
        .align_frame (align_frame)
    );

    task automatic chk(input logic act, input logic exp, input string req);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: actual %0b expected %0b at %0t", req, act, exp, $time);
        end
    endtask

    // One frame of len cycles; strobe=0 relies on the free-running wrap (R9).
    task automatic run_frame(input logic strobe, input logic [5:0] user,
                             input logic intl, input logic scramble,
                             input int len, input string ctx);
        logic [7:0] w;
        @(negedge clk);
        frame_start = strobe;
        user_bits   = user;
        intl_bit    = intl;
        exp_align   = !exp_align;                  // R5 alternation
        w = exp_align ? {intl, 7'b0011011}         // R3
                      : {intl, 1'b1, user};        // R4
        @(posedge clk); #2;
        for (int k = 0; k < len; k++) begin
            if (k > 0) begin
                @(negedge clk);
                frame_start = 1'b0;
                if (scramble) begin                // R8: late changes ignored
                    user_bits = ~user;
                    intl_bit  = ~intl;
                end
                @(posedge clk); #2;
            end
            if (k < 8)
                chk(tx_data, w[7-k], {ctx, exp_align ? " R2 R3 bit" : " R2 R4 bit"});
            else
                chk(tx_data, 1'b0, {ctx, " R7 idle"});
            chk(align_frame, exp_align, {ctx, " R6 status"});
        end
    endtask

    initial begin
        #(100000 * 10);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog: actual running expected finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        // R1: reset state, and no output before the first strobe.
        intl_bit  = 1'b1;
        user_bits = 6'h3F;
        repeat (3) @(posedge clk);
        #2;
        chk(tx_data, 1'b0, "R1 reset data");
        chk(align_frame, 1'b0, "R1 reset status");
        @(negedge clk);
        rst_n = 1'b1;
        for (int c = 0; c < 40; c++) begin
            @(posedge clk); #2;
            chk(tx_data, 1'b0, "R1 unsynced data");
            chk(align_frame, 1'b0, "R1 unsynced status");
        end

        // Sweep: all user patterns, both first-bit values, strobed and wrapped frames.
        for (int i = 0; i < 128; i++) begin
            run_frame((i == 0) || (i % 5 == 0), 6'((i >> 1) & 63),
                      1'((i >> 1) & 1), 1'((i >> 2) & 1), FRAME,
                      (i % 5 == 0) ? "R5 R8 strobed" : "R9 wrapped");
        end

        // R10: early strobes inside timeslot 0 and later in the frame.
        run_frame(1'b1, 6'h2A, 1'b1, 1'b1, 5,  "R10 in-slot restart");
        run_frame(1'b1, 6'h15, 1'b0, 1'b0, 13, "R10 mid-frame restart");
        run_frame(1'b1, 6'h3F, 1'b1, 1'b0, FRAME, "R10 after restart");
        run_frame(1'b0, 6'h00, 1'b1, 1'b1, FRAME, "R9 wrap after restart");
        run_frame(1'b0, 6'h01, 1'b0, 1'b1, FRAME, "R9 second wrap");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule